// File: doc/BRIEF.md
# ADC Conversion Start and Clock Control

This block is the digital control wrapped around a successive-approximation converter. It turns the system clock into a slower converter clock through a power-of-two prescaler. It picks one of several trigger inputs and watches that input for rising edges. It runs each conversion as a short sample phase followed by one comparator decision per result bit, MSB first. At the end it latches the result and raises a sticky completion flag.

A conversion starts in one of two ways. Software can pulse the start input. When auto-triggering is on, a rising edge on the selected trigger input also starts one. Trigger select code 0 picks the block's own completion event, so every finished conversion launches the next one. This gives continuous free-running sampling once software has started the first conversion. The busy output plays the part of the start bit read back. The analog comparator, the trial DAC, the reference and the register bus are outside this block.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After a synchronous reset, `busy`, `done_flag`, `result` and `dac_code` are all zero.
- R2: The converter clock period D is 2 system cycles for `div_sel` 0 and 1, and 2^`div_sel` cycles for `div_sel` 2 to 7. A conversion lasts 13 converter periods: 3 sample ticks and 10 decision ticks. Measured from the edge that takes the start to the edge that ends the conversion, it takes between 12·D+1 and 13·D system cycles.
- R3: The first trial code presented on `dac_code` is 0x200. Each decision keeps the bit under test when `cmp_in` is 1 and clears it when `cmp_in` is 0, working from bit 9 down to bit 0. With `cmp_in` high whenever `dac_code` is at or below the input level, `result` equals that level. `result` changes only at the end of a conversion.
- R4: `busy` is 1 from the edge after a start is accepted until the conversion ends, and is 0 at all other times. It reads the same however the conversion was started. On the edge that ends a conversion, `result` is updated and `busy` falls. `done_flag` rises one cycle later.
- R5: With `enable` high and the block idle, a one-cycle pulse on `start_wr` starts a conversion.
- R6: While `enable` is low, the prescaler is held in reset and `start_wr` and trigger edges start nothing.
- R7: With `auto_en` high, a `trig_sel` value k from 1 to 7 selects `trig_src[k-1]`. A rising edge on that input starts a conversion. A level held high, or an edge on an unselected input, starts nothing further.
- R8: A start pulse or trigger edge that arrives while `busy` is 1 is dropped and not queued.
- R9: With `auto_en` high and `trig_sel` 0, each completion starts the next conversion. The first conversion needs `start_wr`. Conversions keep running while `done_flag` stays set.
- R10: With `auto_en` high and an external input selected, a `start_wr` pulse still starts a single conversion.
- R11: `done_flag` stays set until a `flag_clr` pulse clears it. A completion in the same cycle as a clear wins.
- R12: Dropping `enable` during a conversion makes `busy` 0 on the next edge. `done_flag` is not set and `result` keeps its old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Converter enable; low aborts and holds the prescaler |
| start_wr | input | 1 | Software start pulse |
| auto_en | input | 1 | Auto-trigger enable |
| trig_sel | input | 3 | Trigger select; 0 = own completion event |
| div_sel | input | 3 | Prescaler ratio select |
| flag_clr | input | 1 | Write-one-to-clear pulse for the completion flag |
| trig_src | input | 7 | External trigger inputs |
| cmp_in | input | 1 | Comparator decision for the current trial code |
| busy | output | 1 | Conversion in progress |
| sample | output | 1 | High during the sample phase |
| dac_code | output | 10 | Trial code driven to the DAC |
| result | output | 10 | Last completed conversion result |
| done_flag | output | 1 | Sticky completion flag |

## Verification
The hardest state to reach is a trigger that arrives while a conversion is busy. The stimulus gets there by raising the selected source, letting it fall, and raising it again a few cycles into the conversion. The bench then checks that exactly one completion is reported. Free-running mode with the flag never cleared is reached by selecting code 0 and giving one software start. The bench then counts back-to-back completions while `done_flag` stays high. An abort is placed in the middle of a conversion by dropping `enable` a fixed number of cycles after the start.

// File: rtl/adc_conv_pkg.sv
package adc_conv_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_DECIDE = 2'd2
  } conv_phase_e;

  // log2 of the division ratio: codes 0 and 1 give 1, others give the code,
  // clamped to the counter width.
  function automatic int unsigned div_shift(input int unsigned sel,
                                            input int unsigned cnt_w);
    int unsigned s;
    s = (sel < 2) ? 1 : sel;
    if (s > cnt_w) s = cnt_w;
    return s;
  endfunction

endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
  parameter int PRE_W  = 7,
  parameter int PSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [PSEL_W-1:0] sel,
  output logic              tick
);
  import adc_conv_pkg::*;

  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (i < int'(div_shift(int'(sel), PRE_W))) mask[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= ((cnt & mask) == mask);
    end
  end
endmodule

// File: rtl/adc_trig_detect.sv
module adc_trig_detect #(
  parameter int TSEL_W = 3,
  localparam int NSRC  = (1 << TSEL_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TSEL_W-1:0] sel,
  input  logic [NSRC-1:0]   src,
  input  logic              self_evt,
  output logic              edge_q
);
  logic [NSRC:0] all_src;
  logic          cur;
  logic          prev;

  assign all_src = {src, self_evt};
  assign cur     = all_src[sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      prev   <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      prev   <= cur;
      edge_q <= cur & ~prev;
    end
  end
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
  parameter int RES_W        = 10,
  parameter int SAMPLE_TICKS = 3,
  localparam int STEPS       = SAMPLE_TICKS + RES_W,
  localparam int STEP_W      = $clog2(STEPS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             start,
  input  logic             cmp_in,
  output logic             busy,
  output logic             sample,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] result,
  output logic             done_evt
);
  import adc_conv_pkg::*;

  localparam logic [STEP_W-1:0] LAST_SAMPLE = STEP_W'(SAMPLE_TICKS - 1);
  localparam logic [STEP_W-1:0] LAST_STEP   = STEP_W'(STEPS - 1);
  localparam logic [RES_W-1:0]  MSB_ONE     = {1'b1, {(RES_W-1){1'b0}}};

  conv_phase_e      phase;
  logic [STEP_W-1:0] step;
  logic [RES_W-1:0]  trial;
  logic [RES_W-1:0]  next_trial;
  logic              finish;
  int                pos;

  // Bit under test for the current decision step, and the code that follows it.
  always_comb begin
    pos        = RES_W - 1 - (int'(step) - SAMPLE_TICKS);
    next_trial = trial;
    for (int i = 0; i < RES_W; i++) begin
      if (i == pos && !cmp_in) next_trial[i] = 1'b0;
      if (i == pos - 1)        next_trial[i] = 1'b1;
    end
  end

  assign finish = (phase == PH_DECIDE) && tick && (step == LAST_STEP);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase    <= PH_IDLE;
      step     <= '0;
      trial    <= '0;
      done_evt <= 1'b0;
    end else begin
      done_evt <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase <= PH_SAMPLE;
            step  <= '0;
            trial <= MSB_ONE;
          end
        end
        PH_SAMPLE: begin
          if (tick) begin
            if (step == LAST_SAMPLE) phase <= PH_DECIDE;
            step <= step + 1'b1;
          end
        end
        PH_DECIDE: begin
          if (tick) begin
            trial <= next_trial;
            if (step == LAST_STEP) begin
              phase    <= PH_IDLE;
              step     <= '0;
              done_evt <= 1'b1;
            end else begin
              step <= step + 1'b1;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                result <= '0;
    else if (en && finish)  result <= next_trial;
  end

  assign busy     = (phase != PH_IDLE);
  assign sample   = (phase == PH_SAMPLE);
  assign dac_code = trial;
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl #(
  parameter int RES_W        = 10,
  parameter int PRE_W        = 7,
  parameter int TSEL_W       = 3,
  parameter int PSEL_W       = 3,
  parameter int SAMPLE_TICKS = 3,
  localparam int NSRC        = (1 << TSEL_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              start_wr,
  input  logic              auto_en,
  input  logic [TSEL_W-1:0] trig_sel,
  input  logic [PSEL_W-1:0] div_sel,
  input  logic              flag_clr,
  input  logic [NSRC-1:0]   trig_src,
  input  logic              cmp_in,
  output logic              busy,
  output logic              sample,
  output logic [RES_W-1:0]  dac_code,
  output logic [RES_W-1:0]  result,
  output logic              done_flag
);
  logic tick;
  logic trig_edge;
  logic done_evt;
  logic start_req;

  adc_prescaler #(.PRE_W(PRE_W), .PSEL_W(PSEL_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .en   (enable),
    .sel  (div_sel),
    .tick (tick)
  );

  adc_trig_detect #(.TSEL_W(TSEL_W)) u_trig (
    .clk      (clk),
    .rst      (rst),
    .sel      (trig_sel),
    .src      (trig_src),
    .self_evt (done_evt),
    .edge_q   (trig_edge)
  );

  assign start_req = enable && (start_wr || (auto_en && trig_edge));

  adc_sar_core #(.RES_W(RES_W), .SAMPLE_TICKS(SAMPLE_TICKS)) u_core (
    .clk      (clk),
    .rst      (rst),
    .en       (enable),
    .tick     (tick),
    .start    (start_req),
    .cmp_in   (cmp_in),
    .busy     (busy),
    .sample   (sample),
    .dac_code (dac_code),
    .result   (result),
    .done_evt (done_evt)
  );

  always_ff @(posedge clk) begin
    if (rst)           done_flag <= 1'b0;
    else if (done_evt) done_flag <= 1'b1;
    else if (flag_clr) done_flag <= 1'b0;
  end
endmodule

// File: rtl/adc_conv_ctrl_chk.sv
module adc_conv_ctrl_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             flag_clr,
  input logic             busy,
  input logic             done_flag,
  input logic [RES_W-1:0] result,
  input logic [RES_W-1:0] dac_code
);
  localparam logic [RES_W-1:0] FIRST_TRIAL = {1'b1, {(RES_W-1){1'b0}}};

  assert_abort_clears_busy_R12: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !busy);

  assert_start_needs_enable_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(enable));

  assert_first_trial_msb_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> dac_code == FIRST_TRIAL);

  assert_result_only_at_end_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> $fell(busy));

  assert_flag_follows_end_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && enable && $past(enable)) |=> done_flag);

  assert_flag_clears_by_write_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(done_flag) |-> $past(flag_clr));
endmodule

bind adc_conv_ctrl adc_conv_ctrl_chk #(.RES_W(RES_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .enable    (enable),
  .flag_clr  (flag_clr),
  .busy      (busy),
  .done_flag (done_flag),
  .result    (result),
  .dac_code  (dac_code)
);

// File: tb/adc_conv_ctrl_bench.sv
`timescale 1ns/1ps
module adc_conv_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic       start_wr = 1'b0;
  logic       auto_en = 1'b0;
  logic [2:0] trig_sel = '0;
  logic [2:0] div_sel = '0;
  logic       flag_clr = 1'b0;
  logic [6:0] trig_src = '0;
  logic [9:0] vin = '0;
  logic       cmp_in;
  logic       busy, sample, done_flag;
  logic [9:0] dac_code, result;

  int tests = 0;
  int fails = 0;
  int done_count = 0;
  bit aborting = 1'b0;
  bit finished = 1'b0;
  logic [9:0] exp_q[$];

  always #2.5 clk = ~clk;

  assign cmp_in = (dac_code <= vin);

  adc_conv_ctrl u_adc_conv_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .start_wr(start_wr),
    .auto_en(auto_en), .trig_sel(trig_sel), .div_sel(div_sel),
    .flag_clr(flag_clr), .trig_src(trig_src), .cmp_in(cmp_in),
    .busy(busy), .sample(sample), .dac_code(dac_code),
    .result(result), .done_flag(done_flag)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // Monitor: on each normal completion pop the expected level and compare.
  initial begin
    bit prev_busy = 1'b0;
    bit pend = 1'b0;
    logic [9:0] e;
    forever begin
      @(negedge clk);
      if (pend) begin
        pend = 1'b0;
        done_count++;
        check(done_flag == 1'b1, "R4 flag after completion", done_flag, 1);
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected conversion", result, 0);
        end else begin
          e = exp_q.pop_front();
          check(result == e, "R3 result", result, e);
        end
      end
      if (prev_busy && !busy && !aborting) pend = 1'b1;
      prev_busy = busy;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start_wr = 1'b1;
    @(negedge clk) start_wr = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // Software conversion; returns busy length in system cycles.
  task automatic sw_convert(input logic [9:0] v, output int dur);
    vin = v;
    exp_q.push_back(v);
    pulse_start();
    dur = 0;
    while (busy) begin
      @(negedge clk);
      dur++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic check_dur(input int dur, input int d, input string tag);
    check(dur >= 12*d + 1 && dur <= 13*d, tag, dur, 13*d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int dur;
    int base;
    logic [9:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check(busy == 0 && done_flag == 0, "R1 reset busy/flag", {busy, done_flag}, 0);
    check(result == 0 && dac_code == 0, "R1 reset result/dac", result, 0);

    // R6: disabled, software start ignored
    pulse_start();
    repeat (30) @(negedge clk);
    check(busy == 0 && done_flag == 0, "R6 start while disabled", busy, 0);

    // R5, R2, R3: software conversions at several ratios and levels
    enable = 1'b1;
    div_sel = 3'd0;
    sw_convert(10'h2A5, dur);
    check_dur(dur, 2, "R2 duration div code 0");
    check(done_flag == 1, "R5 software start completes", done_flag, 1);
    div_sel = 3'd1;
    sw_convert(10'h3FF, dur);
    check_dur(dur, 2, "R2 duration div code 1");
    div_sel = 3'd3;
    sw_convert(10'h000, dur);
    check_dur(dur, 8, "R2 duration div code 3");
    div_sel = 3'd2;
    sw_convert(10'h155, dur);
    check_dur(dur, 4, "R2 duration div code 2");

    // R11: clear the flag
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    check(done_flag == 0, "R11 flag cleared", done_flag, 0);

    // R7: edge on selected external source
    div_sel = 3'd0;
    auto_en = 1'b1;
    trig_sel = 3'd3;
    vin = 10'h0F0;
    exp_q.push_back(10'h0F0);
    base = done_count;
    @(negedge clk) trig_src[2] = 1'b1;
    repeat (3) @(negedge clk);
    check(busy == 1, "R7 selected edge starts", busy, 1);
    wait_idle();
    repeat (40) @(negedge clk);
    check(done_count == base + 1, "R7 held level no retrigger", done_count - base, 1);
    trig_src[2] = 1'b0;
    @(negedge clk) trig_src[4] = 1'b1;
    repeat (40) @(negedge clk);
    check(busy == 0 && done_count == base + 1, "R7 unselected source ignored", busy, 0);
    trig_src[4] = 1'b0;

    // R8: second edge during a busy conversion is dropped
    vin = 10'h321;
    exp_q.push_back(10'h321);
    base = done_count;
    @(negedge clk) trig_src[2] = 1'b1;
    @(negedge clk) trig_src[2] = 1'b0;
    repeat (6) @(negedge clk);
    check(busy == 1, "R8 conversion running", busy, 1);
    trig_src[2] = 1'b1;
    @(negedge clk) trig_src[2] = 1'b0;
    start_wr = 1'b1;
    @(negedge clk) start_wr = 1'b0;
    wait_idle();
    repeat (60) @(negedge clk);
    check(done_count == base + 1 && busy == 0, "R8 busy trigger not queued", done_count - base, 1);

    // R10: software start while auto-trigger on an external source
    base = done_count;
    sw_convert(10'h07E, dur);
    check(done_count == base + 1, "R10 software start under auto", done_count - base, 1);

    // R9: free-running from completion event
    trig_sel = 3'd0;
    repeat (60) @(negedge clk);
    check(busy == 0, "R9 no start without software", busy, 0);
    vin = 10'h1C3;
    for (int i = 0; i < 6; i++) exp_q.push_back(10'h1C3);
    base = done_count;
    pulse_start();
    while (done_count < base + 3) @(negedge clk);
    check(done_flag == 1, "R9 flag left set", done_flag, 1);
    auto_en = 1'b0;
    wait_idle();
    check(done_count >= base + 3, "R9 back-to-back conversions", done_count - base, 3);
    exp_q.delete();

    // R11: set wins over clear (pulse clear on the completion cycle window)
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    exp_q.push_back(10'h2AA);
    vin = 10'h2AA;
    pulse_start();
    while (busy) @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    @(negedge clk);
    check(done_flag == 1, "R11 completion beats clear", done_flag, 1);
    repeat (3) @(negedge clk);
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;

    // R12: abort by dropping enable
    held = result;
    div_sel = 3'd2;
    vin = 10'h011;
    pulse_start();
    repeat (10) @(negedge clk);
    check(busy == 1, "R12 conversion in progress", busy, 1);
    aborting = 1'b1;
    enable = 1'b0;
    @(negedge clk);
    check(busy == 0, "R12 busy cleared on abort", busy, 0);
    repeat (80) @(negedge clk);
    check(done_flag == 0, "R12 no flag after abort", done_flag, 0);
    check(result == held, "R12 result kept", result, held);
    aborting = 1'b0;

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule